// File: doc/BRIEF.md
# NAND Page Program Sequencer

This block sits on the host side of a multiplexed x8 NAND bus with large pages and programs one page per request. A request carries a block number, a page number, a column offset, a select between the main area and the spare area, a byte count and a density flag. The sequencer first screens the request: a low write-protect input and an out-of-range byte window are each answered at once with an error code, and no bus cycle is issued. An accepted request becomes the load command, four or five address cycles, the data bytes drawn from a ready/valid stream, and the confirm command. The sequencer then sends the status command once and samples the status byte at a fixed interval until the device reports ready.

Every bus cycle comes from one strobe engine. The engine holds the latch enables and the output byte steady, drives the write strobe low for `STROBE_CLKS` clocks and then high for the same count. A status sample uses the read strobe with the same timing. Chip enable is active for the whole of a busy period. The result is given as a one-cycle `done` pulse with a result code.

The state machine has these states: `S_IDLE` (waiting; screening requests), `S_CMD` (load command), `S_ADDR` (address cycles), `S_DATA` (data bytes), `S_CONF` (confirm command), `S_STAT` (status command), `S_WAIT` (poll interval) and `S_READ` (status sample). Its transitions are:

- S_IDLE→S_CMD on a clean request.
- S_CMD→S_ADDR when the load cycle ends.
- S_ADDR→S_DATA after the last address cycle.
- S_DATA→S_CONF after the last byte.
- S_CONF→S_STAT, then S_STAT→S_WAIT, each when its cycle ends.
- S_WAIT→S_READ when the interval has elapsed.
- S_READ→S_WAIT while the device is busy.
- S_READ→S_IDLE once the device is ready.

Top module: `nand_prog_seq`

## Requirements
- R1: When `wp_n` is low as a request arrives, the block pulses `done` one clock later with result 80h and issues no bus cycle. This check takes priority over R2.
- R2: The effective column is the column input plus 2048 when `req_spare` is 1. If `req_len` is 0, or the effective column plus `req_len` exceeds 2112, the request is rejected with result 04h and no bus cycle is issued.
- R3: An accepted request produces these write cycles in order: command 80h with CLE high, the address cycles with ALE high, the data bytes with both latches low, command 10h, then command 70h. After 70h, the only bus activity is read-strobe cycles.
- R4: The block issues exactly 4 address cycles when `req_big` is 0 and exactly 5 when it is 1.
- R5: Address cycle 1 carries effective column bits 7:0. Cycle 2 carries column bits 11:8 in bits 3:0, with bits 7:4 at zero.
- R6: Address cycle 3 carries `{block[1:0], page[5:0]}`. Cycle 4 carries block bits 9:2. Cycle 5, when present, carries the block bits from bit 10 upward, with its unused upper bits at zero.
- R7: In a spare access, column bit 11 is set and the column equals 2048 plus the offset. For example, offset 55 gives address bytes 37h and 08h.
- R8: Exactly `req_len` data bytes are written, in stream order. Each one is taken only on a cycle with `din_ready` and `din_valid` both high.
- R9: Each write or read strobe stays low for `STROBE_CLKS` clocks. The two strobes are never low at the same time.
- R10: Polling continues while status bit 6 is 0, and bit 0 is ignored in those samples. The first sample with bit 6 set ends the operation with result 01h if bit 0 is set and 00h otherwise.
- R11: `busy` is high from the clock after acceptance until the clock of `done`. `done` lasts exactly one clock. `nand_ce_n` is low only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start pulse, sampled while idle |
| req_block | input | BLK_W | Block number |
| req_page | input | 6 | Page within the block |
| req_col | input | 12 | Column offset in the main or spare area |
| req_spare | input | 1 | 1 selects the spare area |
| req_len | input | 12 | Number of bytes to write |
| req_big | input | 1 | 1 selects five address cycles |
| wp_n | input | 1 | Write protect, active low |
| din_data | input | 8 | Data stream byte |
| din_valid | input | 1 | Data stream valid |
| din_ready | output | 1 | Data byte taken this cycle |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Bus byte driven by the block |
| nand_io_oe | output | 1 | Output enable for nand_io_out |
| nand_io_in | input | 8 | Bus byte from the device |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 8 | 00h pass, 01h fail, 04h overflow, 80h write protected |

## Verification
The bench targets several corners:

- **Byte window exactly at 2112 and one byte beyond.** A design with an off-by-one error would either reject a full page or write past the spare area.
- **The spare offset example.** This catches a design that leaves out the 2048 base or misplaces bit 11.
- **Both address densities.** A design that gets this wrong emits a stray fifth cycle or drops block bits.
- **Busy status samples that have bit 0 set.** A design that reads bit 0 before bit 6 would report a false failure.
- **A request that is both write-protected and overflowing.** This checks that the block answers 80h and never touches the bus.

// File: rtl/nps_pkg.sv
package nps_pkg;
    typedef enum logic [1:0] {K_CMD, K_ADR, K_DAT, K_RD} bus_kind_e;

    typedef enum logic [3:0] {
        S_IDLE, S_CMD, S_ADDR, S_DATA, S_CONF, S_STAT, S_WAIT, S_READ
    } seq_state_e;

    localparam logic [7:0] OP_LOAD = 8'h80;
    localparam logic [7:0] OP_GO   = 8'h10;
    localparam logic [7:0] OP_STAT = 8'h70;

    localparam logic [7:0] RES_PASS = 8'h00;
    localparam logic [7:0] RES_FAIL = 8'h01;
    localparam logic [7:0] RES_OVF  = 8'h04;
    localparam logic [7:0] RES_WP   = 8'h80;

    localparam int MAIN_BYTES = 2048;
    localparam int PAGE_BYTES = 2112;
endpackage

// File: rtl/nps_strobe.sv
module nps_strobe #(
    parameter int STROBE_CLKS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go,
    input  nps_pkg::bus_kind_e  kind_i,
    input  logic [7:0]          byte_i,
    input  logic [7:0]          io_in,
    output logic                active,
    output logic                fin,
    output logic                we_n,
    output logic                re_n,
    output logic                cle,
    output logic                ale,
    output logic [7:0]          io_out,
    output logic                io_oe,
    output logic [7:0]          smp
);
    import nps_pkg::*;

    localparam int LAST  = 2 * STROBE_CLKS - 1;
    localparam int CNT_W = (LAST < 2) ? 1 : $clog2(LAST + 1);

    logic [CNT_W-1:0] cnt;
    bus_kind_e        kind_q;
    logic [7:0]       byte_q;
    logic             low_ph;

    assign low_ph = active && (int'(cnt) < STROBE_CLKS);
    assign fin    = active && (int'(cnt) == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
            kind_q <= K_CMD;
            byte_q <= 8'h00;
            smp    <= 8'h00;
        end else if (!active) begin
            if (go) begin
                active <= 1'b1;
                cnt    <= '0;
                kind_q <= kind_i;
                byte_q <= byte_i;
            end
        end else begin
            if (kind_q == K_RD && int'(cnt) == STROBE_CLKS - 1)
                smp <= io_in;
            if (fin) active <= 1'b0;
            else     cnt    <= cnt + 1'b1;
        end
    end

    always_comb begin
        we_n   = !(low_ph && kind_q != K_RD);
        re_n   = !(low_ph && kind_q == K_RD);
        cle    = active && kind_q == K_CMD;
        ale    = active && kind_q == K_ADR;
        io_oe  = active && kind_q != K_RD;
        io_out = io_oe ? byte_q : 8'h00;
    end

    // R9: the two strobes never overlap
    p_strobes_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));

    // R9: byte and latch enables stay steady inside one bus cycle
    p_io_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !fin) |=> ($stable(io_out) && $stable(cle) && $stable(ale)));

    generate
        if (STROBE_CLKS > 1) begin : g_wide
            // R9: a falling write strobe is held low on the next clock
            p_we_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(we_n) |=> !we_n);
        end
    endgenerate
endmodule

// File: rtl/nps_addr_fmt.sv
module nps_addr_fmt #(
    parameter int BLK_W = 13
) (
    input  logic [11:0]      col,
    input  logic [5:0]       page,
    input  logic [BLK_W-1:0] block,
    input  logic [2:0]       idx,
    output logic [7:0]       byte_o
);
    localparam int PAD_W = 24;
    logic [PAD_W-1:0] blk;

    assign blk = PAD_W'(block);

    always_comb begin
        unique case (idx)
            3'd0:    byte_o = col[7:0];
            3'd1:    byte_o = {4'h0, col[11:8]};
            3'd2:    byte_o = {blk[1:0], page};
            3'd3:    byte_o = blk[9:2];
            3'd4:    byte_o = blk[17:10];
            default: byte_o = 8'h00;
        endcase
    end

    initial begin
        if (BLK_W > 18) $error("block number wider than the address cycles");
    end
endmodule

// File: rtl/nand_prog_seq.sv
module nand_prog_seq #(
    parameter int STROBE_CLKS = 2,
    parameter int POLL_GAP    = 6,
    parameter int BLK_W       = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [BLK_W-1:0] req_block,
    input  logic [5:0]       req_page,
    input  logic [11:0]      req_col,
    input  logic             req_spare,
    input  logic [11:0]      req_len,
    input  logic             req_big,
    input  logic             wp_n,
    input  logic [7:0]       din_data,
    input  logic             din_valid,
    output logic             din_ready,
    output logic             nand_ce_n,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic [7:0]       nand_io_out,
    output logic             nand_io_oe,
    input  logic [7:0]       nand_io_in,
    output logic             busy,
    output logic             done,
    output logic [7:0]       result
);
    import nps_pkg::*;

    localparam int GAP_W = (POLL_GAP < 2) ? 1 : $clog2(POLL_GAP);
    localparam int END_W = 14;

    seq_state_e       state, nxt;
    logic [BLK_W-1:0] blk_q;
    logic [5:0]       page_q;
    logic [11:0]      col_q, len_q;
    logic             big_q;
    logic [2:0]       aidx;
    logic [GAP_W-1:0] gap_cnt;

    logic             go, st_act, st_fin;
    bus_kind_e        kind;
    logic [7:0]       bus_byte, addr_byte, smp;
    logic [END_W-1:0] col_eff, win_end;
    logic             ovf, last_addr;

    assign col_eff   = END_W'(req_col) + (req_spare ? END_W'(MAIN_BYTES) : '0);
    assign win_end   = col_eff + END_W'(req_len);
    assign ovf       = (req_len == 12'd0) || (win_end > END_W'(PAGE_BYTES));
    assign last_addr = (aidx == (big_q ? 3'd4 : 3'd3));
    assign busy      = (state != S_IDLE);
    assign nand_ce_n = !busy;

    nps_addr_fmt #(.BLK_W(BLK_W)) i_fmt (
        .col(col_q), .page(page_q), .block(blk_q), .idx(aidx), .byte_o(addr_byte)
    );

    nps_strobe #(.STROBE_CLKS(STROBE_CLKS)) i_stb (
        .clk(clk), .rst_n(rst_n), .go(go), .kind_i(kind), .byte_i(bus_byte),
        .io_in(nand_io_in), .active(st_act), .fin(st_fin),
        .we_n(nand_we_n), .re_n(nand_re_n), .cle(nand_cle), .ale(nand_ale),
        .io_out(nand_io_out), .io_oe(nand_io_oe), .smp(smp)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (req_valid && wp_n && !ovf) nxt = S_CMD;
            S_CMD:  if (st_fin) nxt = S_ADDR;
            S_ADDR: if (st_fin && last_addr) nxt = S_DATA;
            S_DATA: if (st_fin && len_q == 12'd1) nxt = S_CONF;
            S_CONF: if (st_fin) nxt = S_STAT;
            S_STAT: if (st_fin) nxt = S_WAIT;
            S_WAIT: if (gap_cnt == '0) nxt = S_READ;
            S_READ: if (st_fin) nxt = smp[6] ? S_IDLE : S_WAIT;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            blk_q   <= '0;
            page_q  <= '0;
            col_q   <= '0;
            len_q   <= '0;
            big_q   <= 1'b0;
            aidx    <= '0;
            gap_cnt <= '0;
            done    <= 1'b0;
            result  <= RES_PASS;
        end else begin
            state <= nxt;
            done  <= 1'b0;
            if (state == S_IDLE && req_valid) begin
                blk_q  <= req_block;
                page_q <= req_page;
                col_q  <= col_eff[11:0];
                len_q  <= req_len;
                big_q  <= req_big;
                aidx   <= '0;
                if (!wp_n) begin
                    done <= 1'b1; result <= RES_WP;
                end else if (ovf) begin
                    done <= 1'b1; result <= RES_OVF;
                end
            end
            if (state == S_ADDR && st_fin) aidx <= aidx + 3'd1;
            if (state == S_DATA && st_fin) len_q <= len_q - 12'd1;
            if (nxt == S_WAIT && state != S_WAIT) gap_cnt <= GAP_W'(POLL_GAP - 1);
            else if (state == S_WAIT) gap_cnt <= gap_cnt - 1'b1;
            if (state == S_READ && st_fin && smp[6]) begin
                done   <= 1'b1;
                result <= smp[0] ? RES_FAIL : RES_PASS;
            end
        end
    end

    always_comb begin
        go        = 1'b0;
        kind      = K_CMD;
        bus_byte  = 8'h00;
        din_ready = 1'b0;
        unique case (state)
            S_CMD:  begin bus_byte = OP_LOAD; go = !st_act; end
            S_ADDR: begin kind = K_ADR; bus_byte = addr_byte; go = !st_act; end
            S_DATA: begin
                kind = K_DAT; bus_byte = din_data;
                go = !st_act && din_valid; din_ready = go;
            end
            S_CONF: begin bus_byte = OP_GO; go = !st_act; end
            S_STAT: begin bus_byte = OP_STAT; go = !st_act; end
            S_READ: begin kind = K_RD; go = !st_act; end
            default: ;
        endcase
    end

    // R1: an idle block never strobes the bus
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (nand_we_n && nand_re_n));
    // R1: a protected request is answered next clock with 80h
    p_wp_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && !wp_n) |=> (done && result == RES_WP && !busy));
    // R4: address latch only during address cycles
    p_ale_in_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        nand_ale |-> (state == S_ADDR));
    // R8: a byte is taken only when offered
    p_take_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        din_ready |-> din_valid);
    // R11: done is a single clock and coincides with idle
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: tb/test_nand_prog_seq.sv
module test_nand_prog_seq;
    localparam int S = 2;
    localparam int BW = 13;
    localparam int LIM = 40000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, req_spare = 0, req_big = 0, wp_n = 1;
    logic [BW-1:0] req_block = '0;
    logic [5:0] req_page = '0;
    logic [11:0] req_col = '0, req_len = '0;
    logic [7:0] din_data, nand_io_in;
    logic din_valid = 1'b1, din_ready;
    logic nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
    logic [7:0] nand_io_out, result;
    logic busy, done;

    always #10 clk = ~clk;

    nand_prog_seq #(.STROBE_CLKS(S), .POLL_GAP(6), .BLK_W(BW)) i_nand_prog_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_block(req_block),
        .req_page(req_page), .req_col(req_col), .req_spare(req_spare),
        .req_len(req_len), .req_big(req_big), .wp_n(wp_n), .din_data(din_data),
        .din_valid(din_valid), .din_ready(din_ready), .nand_ce_n(nand_ce_n),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe),
        .nand_io_in(nand_io_in), .busy(busy), .done(done), .result(result)
    );

    int n_chk = 0, n_bad = 0;
    logic [7:0] src [0:2199];
    int src_idx = 0;
    logic take;
    assign din_data = src[src_idx];
    always @(negedge clk) take = din_ready && din_valid;
    always @(posedge clk) if (take) src_idx <= src_idx + 1;

    // device model: status answer depends on how many samples it has seen
    int polls = 0, busy_polls = 0;
    logic [7:0] busy_stat = 8'h01, final_stat = 8'h40;
    assign nand_io_in = (polls < busy_polls) ? busy_stat : final_stat;

    // bus monitor
    logic [1:0] lg_kind [0:2299];
    logic [7:0] lg_byte [0:2299];
    int lg_n = 0, lowcnt = 0, rlow = 0, stb_err = 0;
    logic pw = 1'b1, pr = 1'b1;
    always @(negedge clk) begin
        if (!nand_we_n) lowcnt++;
        if (!nand_re_n) rlow++;
        if (!nand_we_n && !nand_re_n) stb_err++;
        if ((!nand_we_n || !nand_re_n) && nand_ce_n) stb_err++;
        if (!pw && nand_we_n) begin
            if (lowcnt != S) stb_err++;
            if (lg_n < 2300) begin
                lg_kind[lg_n] = nand_cle ? 2'd0 : (nand_ale ? 2'd1 : 2'd2);
                lg_byte[lg_n] = nand_io_out;
            end
            lg_n++;
            lowcnt = 0;
        end
        if (!pr && nand_re_n) begin
            if (rlow != S) stb_err++;
            polls++;
            rlow = 0;
        end
        pw = nand_we_n;
        pr = nand_re_n;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_addr(input int col, input int page,
                                            input int blk, input int i);
        case (i)
            0: return col[7:0];
            1: return {4'h0, col[11:8]};
            2: return {blk[1:0], page[5:0]};
            3: return blk[9:2];
            default: return blk[17:10];
        endcase
    endfunction

    function automatic logic [7:0] exp_code(input bit wp, input int colx,
                                            input int len, input bit fail);
        if (!wp) return 8'h80;
        if (len == 0 || colx + len > 2112) return 8'h04;
        return fail ? 8'h01 : 8'h00;
    endfunction

    // one full request: stimulus, wait, and checks against the requirements
    task automatic run(input int blk, input int page, input int col, input bit spare,
                       input int len, input bit big, input bit wp, input int bp,
                       input bit fail);
        int colx = col + (spare ? 2048 : 0);
        int na = big ? 5 : 4;
        logic [7:0] code = exp_code(wp, colx, len, fail);
        bit accepted = (code == 8'h00 || code == 8'h01);
        int g = 0;
        bit bad;
        for (int i = 0; i < 2200; i++) src[i] = 8'($urandom);
        src_idx = 0; lg_n = 0; polls = 0; stb_err = 0;
        busy_polls = bp;
        busy_stat = (8'($urandom) & 8'hBE) | 8'h01;
        final_stat = 8'h40 | {7'h0, fail};
        req_block = BW'(blk); req_page = 6'(page); req_col = 12'(col);
        req_spare = spare; req_len = 12'(len); req_big = big; wp_n = wp;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (accepted) check(busy == 1'b1 && !done, "R11", "busy after accept", busy, 1);
        while (!done && g < LIM) begin @(negedge clk); g++; end
        if (g >= LIM) begin
            check(1'b0, "R11", "watchdog expired", g, LIM);
            return;
        end
        check(result == code, accepted ? "R10" : (wp ? "R2" : "R1"),
              "result code", result, code);
        @(negedge clk);
        check(!done && !busy && nand_ce_n, "R11", "done width/idle", done, 0);
        if (!accepted) begin
            check(lg_n == 0 && polls == 0, wp ? "R2" : "R1", "bus cycles on reject", lg_n, 0);
            return;
        end
        check(lg_n == 1 + na + len + 2, "R4", "write cycle count", lg_n, 1 + na + len + 2);
        if (lg_n != 1 + na + len + 2) return;
        check(lg_kind[0] == 0 && lg_byte[0] == 8'h80, "R3", "load command", lg_byte[0], 8'h80);
        bad = 0;
        for (int i = 0; i < na; i++)
            if (lg_kind[1+i] != 1 || lg_byte[1+i] != exp_addr(colx, page, blk, i)) begin
                if (!bad) check(1'b0, (i < 2) ? (spare ? "R7" : "R5") : "R6",
                                "address byte", lg_byte[1+i], exp_addr(colx, page, blk, i));
                bad = 1;
            end
        if (!bad) check(1'b1, "R6", "address bytes", 0, 0);
        bad = 0;
        for (int i = 0; i < len; i++)
            if (lg_kind[1+na+i] != 2 || lg_byte[1+na+i] != src[i]) begin
                if (!bad) check(1'b0, "R8", "data byte", lg_byte[1+na+i], src[i]);
                bad = 1;
            end
        if (!bad) check(src_idx == len, "R8", "bytes taken from stream", src_idx, len);
        check(lg_kind[1+na+len] == 0 && lg_byte[1+na+len] == 8'h10, "R3", "confirm command",
              lg_byte[1+na+len], 8'h10);
        check(lg_kind[2+na+len] == 0 && lg_byte[2+na+len] == 8'h70, "R3", "status command",
              lg_byte[2+na+len], 8'h70);
        check(polls == bp + 1, "R10", "status samples", polls, bp + 1);
        check(stb_err == 0, "R9", "strobe width/overlap errors", stb_err, 0);
    endtask

    initial begin
        process::self().srandom(32'd20240611);
        repeat (3) @(negedge clk);
        // reset state
        check(!busy && !done && nand_ce_n && nand_we_n && nand_re_n && result == 8'h00,
              "R11", "reset state", {busy, done, nand_we_n}, 3'b001);
        rst_n = 1'b1;
        @(negedge clk);
        // directed corners
        run(12'h20, 6'h19, 0, 0, 16, 0, 1, 0, 0);          // R5 R6 small density
        run(13'h1ABC, 6'h3F, 300, 0, 5, 1, 1, 2, 0);       // R4 five cycles
        run(7, 3, 55, 1, 9, 0, 1, 1, 0);                   // R7 spare 55 -> 37h 08h, ends at 2112
        run(7, 3, 55, 1, 10, 0, 1, 0, 0);                  // R2 one past the end
        run(1, 1, 0, 0, 0, 0, 1, 0, 0);                    // R2 zero length
        run(1, 1, 2100, 0, 50, 0, 0, 0, 0);                // R1 takes priority over R2
        run(9, 9, 10, 0, 4, 1, 0, 0, 0);                   // R1 clean request protected
        run(3, 2, 0, 0, 2112, 1, 1, 1, 0);                 // R8 full page
        run(5, 6, 1, 0, 3, 0, 1, 3, 1);                    // R10 fail after busy samples
        run(5, 6, 63, 1, 1, 1, 1, 0, 1);                   // R10 immediate fail, last spare byte
        // constrained random
        for (int t = 0; t < 24; t++) begin
            int len = 1 + int'($urandom % 40);
            bit sp = ($urandom % 4) == 0;
            int col = sp ? int'($urandom % 64) : int'($urandom % 2112);
            if (($urandom % 6) != 0) begin
                if (col + (sp ? 2048 : 0) + len > 2112) col = 2112 - len - (sp ? 2048 : 0);
                if (col < 0) col = 0;
            end
            run(int'($urandom % 8192), int'($urandom % 64), col, sp, len,
                1'($urandom), ($urandom % 8) != 0, int'($urandom % 4), 1'($urandom));
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule